// File: doc/BRIEF.md
# Receive Frame Buffer Writer

This block sits between a receive byte stream and a per-frame byte buffer. While the receive-valid input is high it stores each strobed byte into the buffer. Storage starts at address 2, because the first two locations are kept for the frame length. When the frame ends, the block appends the fixed byte 0xEA right after the last stored byte. It then writes the length, low byte at address 0 and high byte at address 1. Some cycles later it pulses a completion output so that an allocator can hand the buffer on.

Two clock domains are involved. Requests are formed in the receive clock domain. The buffer write port runs in a separate write clock domain. Each request flips a toggle bit and holds its address and data steady. The write side passes the toggle through a synchroniser and performs exactly one buffer write for each edge it detects. The block issues the marker and the two length writes itself, and it spaces them apart so that no two toggle flips can merge. End of frame is filtered: the frame ends only after the valid input has stayed low for several consecutive cycles. A short dropout in the middle of a frame therefore cannot truncate it.

Top module: `rx_frame_writer`

## Requirements
- R1: After reset, buf_we_o and frame_done_o are low. No buffer write occurs until a frame is received.
- R2: Each byte strobe inside a frame produces exactly one buffer write. Payload bytes go in arrival order to addresses 2, 3, 4 and upward.
- R3: The byte value 0xEA is written to the address directly after the last stored payload byte. For an empty frame that address is 2.
- R4: A frame ends only after rx_valid_i has been sampled low on EOF_IDLE (default 3) consecutive receive clock edges. A dropout of two low cycles followed by high continues the same frame.
- R5: The length is the number of stored payload bytes. Its low byte is written to address 0 and its high byte (bits 15:8, zero-extended) to address 1. The last three writes of a frame go, in this order, to the marker address, then 0, then 1. The block's own requests are at least REQ_GAP (default 4) receive cycles apart.
- R6: frame_done_o is high for exactly one receive cycle, DONE_DLY (default 15) receive cycles after the length-high request. When the last strobe is sampled at edge E and valid is sampled low from edge E+1, the pulse follows edge E+27.
- R7: Byte strobes that arrive between end of frame and the completion pulse cause no buffer write.
- R8: Once address 2^ADDR_W-1 is reached, further payload bytes are dropped. The marker goes to that last address, and the length counts only the stored bytes.
- R9: A frame of N stored bytes causes exactly N+3 buffer writes in the write clock domain.
- R10: A frame with no byte strobes still gets the marker at address 2 and a length of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk_i | input | 1 | Receive clock |
| wr_clk_i | input | 1 | Buffer write clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| rx_valid_i | input | 1 | Frame reception in progress |
| rx_byte_stb_i | input | 1 | One-cycle strobe: rx_byte_i holds a new byte |
| rx_byte_i | input | 8 | Received byte |
| frame_done_o | output | 1 | One-cycle completion pulse, receive domain |
| buf_we_o | output | 1 | Buffer write enable, write domain |
| buf_addr_o | output | ADDR_W | Buffer write address |
| buf_data_o | output | 8 | Buffer write data |

## Verification
The bench builds the block with ADDR_W=9, which gives a 512-byte buffer. This makes the capacity limit reachable with a 520-byte frame. A 300-byte frame gives a non-zero high length byte. All timing parameters keep their defaults, so the 27-cycle distance from the last strobe to the completion pulse can be checked exactly. The write clock is faster than the receive clock and has an unrelated period, so every request crosses a real synchroniser and the bench counts that each one lands exactly once.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_MARK,
    ST_LEN_LO,
    ST_LEN_HI,
    ST_DONE
  } wr_state_e;
endpackage

// File: rtl/rxw_eof_filter.sv
module rxw_eof_filter #(
  parameter int IDLE_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic valid_i,
  output logic eof_o
);
  localparam int CW = $clog2(IDLE_CYC + 1);

  logic [CW-1:0] low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q <= '0;
    end else if (!arm_i || valid_i) begin
      low_q <= '0;
    end else if (low_q != CW'(IDLE_CYC)) begin
      low_q <= low_q + 1'b1;
    end
  end

  // fires on the IDLE_CYC-th consecutive low sample
  assign eof_o = arm_i && !valid_i && (low_q == CW'(IDLE_CYC - 1));
endmodule

// File: rtl/rxw_seq.sv
module rxw_seq
  import rxw_pkg::*;
#(
  parameter int          ADDR_W   = 11,
  parameter int          REQ_GAP  = 4,
  parameter int          DONE_DLY = 15,
  parameter logic [7:0]  END_MARK = 8'hEA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              stb_i,
  input  logic [7:0]        byte_i,
  input  logic              eof_i,
  output logic              arm_o,
  output logic              req_o,
  output logic              own_req_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [7:0]        req_data_o,
  output wr_state_e         state_o,
  output logic              done_o
);
  localparam logic [ADDR_W-1:0] ADDR_MAX   = '1;
  localparam logic [ADDR_W-1:0] ADDR_FIRST = ADDR_W'(2);
  localparam int GW = $clog2(REQ_GAP + 1);
  localparam int DW = $clog2(DONE_DLY + 1);

  wr_state_e         st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [GW-1:0]     gap_q;
  logic [DW-1:0]     dcnt_q;
  logic              done_q;

  logic              byte_ok, gap_ok, own_fire;
  logic [ADDR_W-1:0] len_w;
  logic [15:0]       len16;

  assign len_w = addr_q - ADDR_FIRST;
  assign len16 = 16'(len_w);
  assign gap_ok = gap_q >= GW'(REQ_GAP - 1);
  assign byte_ok = stb_i && (addr_q != ADDR_MAX) &&
                   ((st_q == ST_RECV) || (st_q == ST_IDLE && valid_i));

  always_comb begin
    own_fire   = 1'b0;
    req_addr_o = addr_q;
    req_data_o = byte_i;
    unique case (st_q)
      ST_MARK: begin
        own_fire   = gap_ok;
        req_data_o = END_MARK;
      end
      ST_LEN_LO: begin
        own_fire   = gap_ok;
        req_addr_o = '0;
        req_data_o = len16[7:0];
      end
      ST_LEN_HI: begin
        own_fire   = gap_ok;
        req_addr_o = ADDR_W'(1);
        req_data_o = len16[15:8];
      end
      default: ;
    endcase
  end

  assign req_o     = byte_ok || own_fire;
  assign own_req_o = own_fire;
  assign arm_o     = (st_q == ST_RECV);
  assign state_o   = st_q;
  assign done_o    = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_q <= ADDR_FIRST;
      gap_q  <= GW'(REQ_GAP);
      dcnt_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (req_o) gap_q <= '0;
      else if (gap_q != GW'(REQ_GAP)) gap_q <= gap_q + 1'b1;

      done_q <= (st_q == ST_DONE) && (dcnt_q == DW'(DONE_DLY - 1));

      unique case (st_q)
        ST_IDLE: begin
          addr_q <= byte_ok ? ADDR_FIRST + 1'b1 : ADDR_FIRST;
          if (valid_i) st_q <= ST_RECV;
        end
        ST_RECV: begin
          if (byte_ok) addr_q <= addr_q + 1'b1;
          if (eof_i) st_q <= ST_MARK;
        end
        ST_MARK:   if (gap_ok) st_q <= ST_LEN_LO;
        ST_LEN_LO: if (gap_ok) st_q <= ST_LEN_HI;
        ST_LEN_HI: begin
          if (gap_ok) begin
            st_q   <= ST_DONE;
            dcnt_q <= '0;
          end
        end
        ST_DONE: begin
          dcnt_q <= dcnt_q + 1'b1;
          if (dcnt_q == DW'(DONE_DLY - 1)) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxw_cdc_write.sv
module rxw_cdc_write #(
  parameter int ADDR_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic              src_clk_i,
  input  logic              dst_clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic              tgl_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        data_o
);
  logic              tgl_q;
  logic [ADDR_W-1:0] hold_addr_q;
  logic [7:0]        hold_data_q;

  // source side: address and data stay put until the next request
  always_ff @(posedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgl_q       <= 1'b0;
      hold_addr_q <= '0;
      hold_data_q <= '0;
    end else if (req_i) begin
      tgl_q       <= ~tgl_q;
      hold_addr_q <= addr_i;
      hold_data_q <= data_i;
    end
  end

  assign tgl_o = tgl_q;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   seen_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge dst_clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[0] <= 1'b0;
        else         sync_q[0] <= tgl_q;
      end
    end else begin : g_next
      always_ff @(posedge dst_clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= sync_q[g-1];
      end
    end
  end

  logic edge_w;
  assign edge_w = sync_q[SYNC_STAGES-1] ^ seen_q;

  always_ff @(posedge dst_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      we_o   <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      seen_q <= sync_q[SYNC_STAGES-1];
      we_o   <= edge_w;
      if (edge_w) begin
        addr_o <= hold_addr_q;
        data_o <= hold_data_q;
      end
    end
  end
endmodule

// File: rtl/rx_frame_writer.sv
module rx_frame_writer
  import rxw_pkg::*;
#(
  parameter int         ADDR_W      = 11,
  parameter int         EOF_IDLE    = 3,
  parameter int         REQ_GAP     = 4,
  parameter int         DONE_DLY    = 15,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] END_MARK    = 8'hEA
) (
  input  logic              rx_clk_i,
  input  logic              wr_clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic              rx_byte_stb_i,
  input  logic [7:0]        rx_byte_i,
  output logic              frame_done_o,
  output logic              buf_we_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic [7:0]        buf_data_o
);
  logic              seq_arm, seq_eof, seq_req, seq_own;
  logic [ADDR_W-1:0] seq_addr;
  logic [7:0]        seq_data;
  wr_state_e         seq_st;
  logic              cdc_tgl;

  rxw_eof_filter #(
    .IDLE_CYC(EOF_IDLE)
  ) i_eof (
    .clk_i  (rx_clk_i),
    .rst_ni (rst_ni),
    .arm_i  (seq_arm),
    .valid_i(rx_valid_i),
    .eof_o  (seq_eof)
  );

  rxw_seq #(
    .ADDR_W  (ADDR_W),
    .REQ_GAP (REQ_GAP),
    .DONE_DLY(DONE_DLY),
    .END_MARK(END_MARK)
  ) i_seq (
    .clk_i     (rx_clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (rx_valid_i),
    .stb_i     (rx_byte_stb_i),
    .byte_i    (rx_byte_i),
    .eof_i     (seq_eof),
    .arm_o     (seq_arm),
    .req_o     (seq_req),
    .own_req_o (seq_own),
    .req_addr_o(seq_addr),
    .req_data_o(seq_data),
    .state_o   (seq_st),
    .done_o    (frame_done_o)
  );

  rxw_cdc_write #(
    .ADDR_W     (ADDR_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_cdc (
    .src_clk_i(rx_clk_i),
    .dst_clk_i(wr_clk_i),
    .rst_ni   (rst_ni),
    .req_i    (seq_req),
    .addr_i   (seq_addr),
    .data_i   (seq_data),
    .tgl_o    (cdc_tgl),
    .we_o     (buf_we_o),
    .addr_o   (buf_addr_o),
    .data_o   (buf_data_o)
  );
endmodule

// File: rtl/rxw_checker.sv
module rxw_checker
  import rxw_pkg::*;
#(
  parameter int EOF_IDLE = 3,
  parameter int REQ_GAP  = 4
) (
  input logic      rx_clk_i,
  input logic      rst_ni,
  input logic      rx_valid_i,
  input wr_state_e st,
  input logic      req,
  input logic      own_req,
  input logic      tgl,
  input logic      frame_done_o
);
  localparam int LW = $clog2(EOF_IDLE + 1);
  localparam int SW = $clog2(REQ_GAP + 1);

  logic [LW-1:0] low_run_q;
  logic [SW-1:0] since_q;

  always_ff @(posedge rx_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_run_q <= '0;
      since_q   <= SW'(REQ_GAP);
    end else begin
      if (rx_valid_i) low_run_q <= '0;
      else if (low_run_q != LW'(EOF_IDLE)) low_run_q <= low_run_q + 1'b1;
      if (req) since_q <= '0;
      else if (since_q != SW'(REQ_GAP)) since_q <= since_q + 1'b1;
    end
  end

  a_r4_eof_filter: assert property (@(posedge rx_clk_i) disable iff (!rst_ni)
    (st == ST_MARK && $past(st) == ST_RECV) |-> (low_run_q >= LW'(EOF_IDLE)));

  a_r5_own_spacing: assert property (@(posedge rx_clk_i) disable iff (!rst_ni)
    own_req |-> (since_q >= SW'(REQ_GAP - 1)));

  a_r6_done_single: assert property (@(posedge rx_clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);

  a_r7_quiet_done: assert property (@(posedge rx_clk_i) disable iff (!rst_ni)
    (st == ST_DONE) |=> $stable(tgl));
endmodule

bind rx_frame_writer rxw_checker #(
  .EOF_IDLE(EOF_IDLE),
  .REQ_GAP (REQ_GAP)
) i_rxw_checker (
  .rx_clk_i    (rx_clk_i),
  .rst_ni      (rst_ni),
  .rx_valid_i  (rx_valid_i),
  .st          (seq_st),
  .req         (seq_req),
  .own_req     (seq_own),
  .tgl         (cdc_tgl),
  .frame_done_o(frame_done_o)
);

// File: tb/test_rx_frame_writer.sv
module test_rx_frame_writer;
  localparam int AW = 9;
  localparam int CAP = (1 << AW) - 3;

  logic          rx_clk = 1'b0, wr_clk = 1'b0, rst_ni = 1'b0;
  logic          rx_valid = 1'b0, rx_stb = 1'b0;
  logic [7:0]    rx_byte = '0;
  logic          frame_done, buf_we;
  logic [AW-1:0] buf_addr;
  logic [7:0]    buf_data;

  always #10 rx_clk = ~rx_clk;
  always #8  wr_clk = ~wr_clk;

  rx_frame_writer #(.ADDR_W(AW)) i_rx_frame_writer (
    .rx_clk_i(rx_clk), .wr_clk_i(wr_clk), .rst_ni(rst_ni),
    .rx_valid_i(rx_valid), .rx_byte_stb_i(rx_stb), .rx_byte_i(rx_byte),
    .frame_done_o(frame_done), .buf_we_o(buf_we),
    .buf_addr_o(buf_addr), .buf_data_o(buf_data)
  );

  logic [7:0] mem [1 << AW];
  int         wr_cnt = 0;
  int         log0 = -1, log1 = -1, log2 = -1;
  int         cyc = 0;
  int         checks = 0, failures = 0;

  always @(posedge wr_clk) if (buf_we) begin
    mem[buf_addr] <= buf_data;
    wr_cnt <= wr_cnt + 1;
    log0 <= log1; log1 <= log2; log2 <= int'(buf_addr);
  end

  always @(posedge rx_clk) cyc <= cyc + 1;

  task automatic check(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // n bytes, optional 2-cycle valid dropout after byte drop_at, optional stray strobe
  task automatic run_frame(input string tag, input int n, input int drop_at,
                           input bit stray, input logic [7:0] seed);
    int base, stored, bad, es;
    stored = (n > CAP) ? CAP : n;
    base = wr_cnt;
    @(negedge rx_clk) rx_valid = 1'b1;
    repeat (4) @(negedge rx_clk);
    for (int i = 0; i < n; i++) begin
      repeat (3) @(negedge rx_clk);
      rx_stb = 1'b1; rx_byte = seed + 8'(i);
      @(negedge rx_clk) rx_stb = 1'b0;
      if (i == drop_at) begin
        rx_valid = 1'b0;
        repeat (2) @(negedge rx_clk);
        rx_valid = 1'b1;
      end
    end
    if (n == 0) @(negedge rx_clk);
    rx_valid = 1'b0;
    es = cyc;
    repeat (5) @(negedge rx_clk);
    if (stray) begin rx_stb = 1'b1; rx_byte = 8'h55; end
    @(negedge rx_clk) rx_stb = 1'b0;
    repeat (20) @(negedge rx_clk);
    check({tag, " R6 done low before delay"}, int'(frame_done), 0);
    check({tag, " R6 cycle count"}, cyc - es, 26);
    @(negedge rx_clk);
    check({tag, " R6 done pulse"}, int'(frame_done), 1);
    @(negedge rx_clk);
    check({tag, " R6 done single cycle"}, int'(frame_done), 0);
    repeat (4) @(negedge rx_clk);
    bad = 0;
    for (int i = 0; i < stored; i++)
      if (mem[2 + i] !== seed + 8'(i)) bad++;
    check({tag, " R2 payload mismatches"}, bad, 0);
    check({tag, " R3 end marker"}, int'(mem[2 + stored]), 8'hEA);
    check({tag, " R5 length low"}, int'(mem[0]), stored & 8'hFF);
    check({tag, " R5 length high"}, int'(mem[1]), stored >> 8);
    check({tag, " R9 write count (R7 stray ignored)"}, wr_cnt - base, stored + 3);
    check({tag, " R5 order marker"}, log0, stored + 2);
    check({tag, " R5 order low"}, log1, 0);
    check({tag, " R5 order high"}, log2, 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge rx_clk);
    check("R1 we after reset", int'(buf_we), 0);
    check("R1 done after reset", int'(frame_done), 0);
    check("R1 no writes", wr_cnt, 0);
  endtask

  task automatic t_short();    run_frame("short R2",  5, -1, 1'b0, 8'h10); endtask
  task automatic t_dropout();  run_frame("dropout R4", 8, 3, 1'b0, 8'h40); endtask
  task automatic t_empty();    run_frame("empty R10", 0, -1, 1'b0, 8'h00); endtask
  task automatic t_long();     run_frame("long R5", 300, -1, 1'b0, 8'h81); endtask
  task automatic t_stray();    run_frame("stray R7", 4, -1, 1'b1, 8'hC0); endtask
  task automatic t_overflow(); run_frame("overflow R8", 520, -1, 1'b0, 8'h07); endtask

  initial begin
    repeat (3) @(negedge rx_clk);
    rst_ni = 1'b1;
    t_reset();
    t_short();
    t_dropout();
    t_empty();
    t_long();
    t_stray();
    t_overflow();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge rx_clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule